// File: doc/BRIEF.md
# HDLC Receive Deframer (64 kbit/s and 56 kbit/s lanes)

This block takes the octet stream of one channel lane and turns it into HDLC frames. It accepts one octet per strobe. It consumes the bits of each octet least significant first: all eight bits in 64k mode, or only bits 0 to 6 in 56k mode. A small hunt machine first looks for a zero and then for a flag. Inside a frame it drops the zeros that the sender inserted, collects the remaining bits into bytes and runs the CRC-16 frame check over them.

A frame is held in an internal buffer until its closing flag arrives. Only a frame that passes the check is played out, one byte per clock, framed by start and end markers. The two check bytes are not played out. Every frame that ends produces a one-cycle event: good, check error, misaligned, oversize or aborted. Three saturating counters sum these events. In a system, the upstream lane extractor drives the octet strobe at line rate, which is far below the clock rate. A downstream packet sink takes the byte stream.

Top module: `hdlc_rx_deframer`

## Requirements
- R1: During and after reset the hunt is in its zero-search state, `out_valid` and every event output are low, and all three counters read zero.
- R2: After a zero has been seen, a zero that follows exactly six ones is a flag. A run of seven ones returns the hunt to zero-search. If this happens while frame bytes are being collected, the frame is discarded and `evt_abort` pulses.
- R3: Octet bits are consumed from bit 0 upward. In 64k mode (`mode_56k`=0) all eight bits are used. In 56k mode (`mode_56k`=1) bit 7 is ignored and only bits 0..6 are used.
- R4: Inside a frame, a zero that follows exactly five ones is removed from the data.
- R5: Each byte is assembled so that its first received bit lands in bit 0. Delivered bytes leave in the order they were received.
- R6: The check is the reflected CRC-16 (polynomial 0x8408, preset 0xFFFF) over every received byte, including the two check bytes. A frame is good when the final value is 0xF0B8 and the frame holds at least 3 bytes. A good frame is delivered without its last two bytes: `out_sof` marks the first byte, `out_eof` the last, and `evt_good` pulses. Any other aligned frame pulses `evt_fcs_err` and delivers nothing.
- R7: The closing flag of one frame can also open the next frame.
- R8: A closing flag that arrives when the bit count is not a multiple of 8 pulses `evt_align_err`, discards the frame and returns the hunt to flag-search.
- R9: A frame of MAX_LEN bytes, including the check bytes, is accepted. Completing byte MAX_LEN+1 pulses `evt_oversize`, discards the frame and returns the hunt to flag-search.
- R10: An octet whose used bits are all ones (0xFF in 64k mode, bits 0..6 set in 56k mode) forces zero-search and clears the bit and ones counters. If a frame was open, it is discarded and `evt_abort` pulses.
- R11: Events pulse for one cycle, in the cycle after the clock edge that samples the octet that caused them. Delivery of a good frame starts in that same cycle and runs one byte per cycle with no gap. At most one event is high at a time.
- R12: `cnt_good` counts `evt_good` and `cnt_fcs_err` counts `evt_fcs_err`. `cnt_drop` counts abort, misalignment and oversize events. Each counter updates one cycle after its event and saturates at its all-ones value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_56k | input | 1 | 1: use 7 bits per octet; 0: use 8 bits |
| oct_valid | input | 1 | Octet strobe |
| oct_data | input | 8 | Lane octet, bit 0 received first |
| out_valid | output | 1 | Delivered byte valid |
| out_data | output | 8 | Delivered frame byte |
| out_sof | output | 1 | First byte of a frame |
| out_eof | output | 1 | Last byte of a frame |
| evt_good | output | 1 | Good frame ended |
| evt_fcs_err | output | 1 | Aligned frame failed the check or was too short |
| evt_align_err | output | 1 | Closing flag not byte aligned |
| evt_oversize | output | 1 | Frame exceeded MAX_LEN bytes |
| evt_abort | output | 1 | Open frame abandoned by a ones run or an all-ones octet |
| cnt_good | output | CNT_W | Saturating good-frame count |
| cnt_fcs_err | output | CNT_W | Saturating check-error count |
| cnt_drop | output | CNT_W | Saturating abort, misalignment and oversize count |

## Verification
An event is due in the cycle right after the edge that samples the octet holding the deciding bit. A good frame's first byte appears in that same cycle, and its remaining bytes follow on consecutive cycles. The counters move one cycle after their event. The driver queues the expected events and bytes as it builds the bit stream, and a monitor compares them at the falling edge whenever an event or `out_valid` is high. Any output that arrives with nothing queued is a mismatch, and queues still holding items at the end are mismatches too. Octets are spaced further apart than the longest delivery, so every result is settled before the next stimulus.

// File: rtl/hdlc_rx_deframer.sv
module hdlc_rx_deframer #(
  parameter int MAX_LEN = 32,
  parameter int CNT_W   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_56k,
  input  logic             oct_valid,
  input  logic [7:0]       oct_data,
  output logic             out_valid,
  output logic [7:0]       out_data,
  output logic             out_sof,
  output logic             out_eof,
  output logic             evt_good,
  output logic             evt_fcs_err,
  output logic             evt_align_err,
  output logic             evt_oversize,
  output logic             evt_abort,
  output logic [CNT_W-1:0] cnt_good,
  output logic [CNT_W-1:0] cnt_fcs_err,
  output logic [CNT_W-1:0] cnt_drop
);
  localparam int LW = $clog2(MAX_LEN + 1);
  localparam logic [15:0] RESIDUE = 16'hF0B8;

  typedef enum logic [1:0] {ZERO_HUNT, FLAG_HUNT, FLAG_SEEN, IN_FRAME} hunt_t;

  function automatic logic [15:0] crc_byte(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c;
    for (int k = 0; k < 8; k++)
      r = (r[0] ^ d[k]) ? ((r >> 1) ^ 16'h8408) : (r >> 1);
    return r;
  endfunction

  function automatic logic [2:0] inc_sat(input logic [2:0] v);
    return (v == 3'd7) ? v : v + 3'd1;
  endfunction

  hunt_t       st_q, st;
  logic [2:0]  ones_q, ones, bc_q, bc;
  logic [7:0]  sh_q, sh;
  logic [LW-1:0] nb_q, nb;
  logic [15:0] fcs_q, fcs;
  logic        bit_v, acc, all_ones;
  logic        wr;
  logic [LW-1:0] wr_idx;
  logic [7:0]  wr_byte;
  logic        e_good, e_fcs, e_align, e_over, e_abort;

  logic [7:0]    mem [0:MAX_LEN-1];
  logic          act_q;
  logic [LW-1:0] rd_q, last_q;

  assign all_ones = mode_56k ? (oct_data[6:0] == 7'h7F) : (oct_data == 8'hFF);

  always_comb begin
    st = st_q; ones = ones_q; bc = bc_q; sh = sh_q; nb = nb_q; fcs = fcs_q;
    bit_v = 1'b0; acc = 1'b0;
    wr = 1'b0; wr_idx = '0; wr_byte = '0;
    e_good = 1'b0; e_fcs = 1'b0; e_align = 1'b0; e_over = 1'b0; e_abort = 1'b0;
    if (oct_valid) begin
      if (all_ones) begin
        if (st_q == IN_FRAME) e_abort = 1'b1;
        st = ZERO_HUNT; ones = '0; bc = '0;
      end else begin
        for (int i = 0; i < 8; i++) begin
          if (i < 7 || !mode_56k) begin
            bit_v = oct_data[i];
            acc = 1'b0;
            case (st)
              ZERO_HUNT: begin
                if (bit_v) ones = inc_sat(ones);
                else begin ones = '0; st = FLAG_HUNT; end
              end
              FLAG_HUNT: begin
                if (bit_v) begin
                  ones = inc_sat(ones);
                  if (ones == 3'd7) st = ZERO_HUNT;
                end else begin
                  if (ones == 3'd6) begin st = FLAG_SEEN; bc = '0; sh = '0; end
                  ones = '0;
                end
              end
              default: begin
                if (bit_v) begin
                  ones = inc_sat(ones);
                  if (ones == 3'd7) begin
                    if (st == IN_FRAME) e_abort = 1'b1;
                    st = ZERO_HUNT;
                  end else acc = 1'b1;
                end else if (ones == 3'd6) begin
                  if (st == IN_FRAME) begin
                    if (bc != 3'd7) begin
                      e_align = 1'b1; st = FLAG_HUNT;
                    end else begin
                      if (fcs == RESIDUE && nb >= LW'(3)) e_good = 1'b1;
                      else e_fcs = 1'b1;
                      st = FLAG_SEEN;
                    end
                  end
                  bc = '0; sh = '0; ones = '0;
                end else if (ones == 3'd5) begin
                  ones = '0;
                end else begin
                  ones = '0; acc = 1'b1;
                end
              end
            endcase
            if (acc) begin
              sh = {bit_v, sh[7:1]};
              bc = bc + 3'd1;
              if (bc == 3'd0) begin
                if (st == FLAG_SEEN) begin
                  st = IN_FRAME; nb = LW'(1); fcs = crc_byte(16'hFFFF, sh);
                  wr = 1'b1; wr_idx = '0; wr_byte = sh;
                end else if (nb == LW'(MAX_LEN)) begin
                  e_over = 1'b1; st = FLAG_HUNT;
                end else begin
                  wr = 1'b1; wr_idx = nb; wr_byte = sh;
                  nb = nb + LW'(1); fcs = crc_byte(fcs, sh);
                end
              end
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= ZERO_HUNT; ones_q <= '0; bc_q <= '0; sh_q <= '0; nb_q <= '0; fcs_q <= 16'hFFFF;
      {evt_good, evt_fcs_err, evt_align_err, evt_oversize, evt_abort} <= '0;
      cnt_good <= '0; cnt_fcs_err <= '0; cnt_drop <= '0;
      act_q <= 1'b0; rd_q <= '0; last_q <= '0;
    end else begin
      st_q <= st; ones_q <= ones; bc_q <= bc; sh_q <= sh; nb_q <= nb; fcs_q <= fcs;
      {evt_good, evt_fcs_err, evt_align_err, evt_oversize, evt_abort} <=
        {e_good, e_fcs, e_align, e_over, e_abort};
      if (evt_good && cnt_good != '1) cnt_good <= cnt_good + 1'b1;
      if (evt_fcs_err && cnt_fcs_err != '1) cnt_fcs_err <= cnt_fcs_err + 1'b1;
      if ((evt_align_err || evt_oversize || evt_abort) && cnt_drop != '1)
        cnt_drop <= cnt_drop + 1'b1;
      if (e_good) begin
        act_q <= 1'b1; rd_q <= '0; last_q <= nb - LW'(3);
      end else if (act_q) begin
        if (rd_q == last_q) act_q <= 1'b0;
        else rd_q <= rd_q + LW'(1);
      end
    end
  end

  always_ff @(posedge clk)
    if (wr) mem[wr_idx] <= wr_byte;

  assign out_valid = act_q;
  assign out_data  = mem[rd_q];
  assign out_sof   = act_q && (rd_q == '0);
  assign out_eof   = act_q && (rd_q == last_q);
endmodule

// File: rtl/hdlc_rx_deframer_chk.sv
module hdlc_rx_deframer_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             oct_valid,
  input logic             out_valid,
  input logic             out_sof,
  input logic             out_eof,
  input logic             evt_good,
  input logic             evt_fcs_err,
  input logic             evt_align_err,
  input logic             evt_oversize,
  input logic             evt_abort,
  input logic [CNT_W-1:0] cnt_good
);
  assert_markers_need_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_sof || out_eof) |-> out_valid);

  assert_single_event_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({evt_good, evt_fcs_err, evt_align_err, evt_oversize, evt_abort}));

  assert_good_starts_delivery_R11: assert property (@(posedge clk) disable iff (!rst_n)
    evt_good |-> (out_valid && out_sof));

  assert_delivery_gapless_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_eof) |=> (out_valid && !out_sof));

  assert_no_event_without_octet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !oct_valid |=> !(evt_good || evt_fcs_err || evt_align_err || evt_oversize || evt_abort));

  assert_good_count_steps_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_good && cnt_good != '1) |=> (cnt_good == $past(cnt_good) + 1'b1));

  assert_good_count_holds_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt_good || cnt_good == '1) |=> $stable(cnt_good));
endmodule

bind hdlc_rx_deframer hdlc_rx_deframer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .oct_valid(oct_valid),
  .out_valid(out_valid), .out_sof(out_sof), .out_eof(out_eof),
  .evt_good(evt_good), .evt_fcs_err(evt_fcs_err), .evt_align_err(evt_align_err),
  .evt_oversize(evt_oversize), .evt_abort(evt_abort), .cnt_good(cnt_good)
);

// File: tb/test_hdlc_rx_deframer.sv
module test_hdlc_rx_deframer;
  localparam int MAX_LEN = 16;
  localparam int CNT_W   = 2;
  localparam int GAP     = MAX_LEN + 2;
  localparam logic [4:0] EV_GOOD = 5'b10000, EV_FCS = 5'b01000, EV_ALIGN = 5'b00100,
                         EV_OVER = 5'b00010, EV_ABORT = 5'b00001;

  logic clk = 1'b0, rst_n = 1'b0, mode_56k = 1'b0, oct_valid = 1'b0;
  logic [7:0] oct_data = '0;
  logic out_valid, out_sof, out_eof;
  logic [7:0] out_data;
  logic evt_good, evt_fcs_err, evt_align_err, evt_oversize, evt_abort;
  logic [CNT_W-1:0] cnt_good, cnt_fcs_err, cnt_drop;

  always #10 clk = ~clk;

  hdlc_rx_deframer #(.MAX_LEN(MAX_LEN), .CNT_W(CNT_W)) i_hdlc_rx_deframer (
    .clk(clk), .rst_n(rst_n), .mode_56k(mode_56k), .oct_valid(oct_valid), .oct_data(oct_data),
    .out_valid(out_valid), .out_data(out_data), .out_sof(out_sof), .out_eof(out_eof),
    .evt_good(evt_good), .evt_fcs_err(evt_fcs_err), .evt_align_err(evt_align_err),
    .evt_oversize(evt_oversize), .evt_abort(evt_abort),
    .cnt_good(cnt_good), .cnt_fcs_err(cnt_fcs_err), .cnt_drop(cnt_drop));

  int checks = 0, fails = 0, run = 0;
  bit bq[$];
  logic [9:0] exp_q[$];
  logic [4:0] ev_q[$];
  logic [7:0] fr[$];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic put_flag();
    bq.push_back(1'b0);
    repeat (6) bq.push_back(1'b1);
    bq.push_back(1'b0);
    run = 0;
  endtask

  task automatic put_ones(input int n);
    repeat (n) bq.push_back(1'b1);
  endtask

  task automatic put_byte(input logic [7:0] d);
    for (int i = 0; i < 8; i++) begin
      bq.push_back(d[i]);
      if (d[i]) begin
        run++;
        if (run == 5) begin bq.push_back(1'b0); run = 0; end
      end else run = 0;
    end
  endtask

  function automatic logic [15:0] calc_fcs();
    logic [15:0] c = 16'hFFFF;
    foreach (fr[j])
      for (int i = 0; i < 8; i++) begin
        logic x;
        x = c[0] ^ fr[j][i];
        c = c >> 1;
        if (x) c = c ^ 16'h8408;
      end
    return ~c;
  endfunction

  task automatic put_frame(input bit corrupt);
    logic [15:0] f;
    f = calc_fcs();
    if (corrupt) f = f ^ 16'h0100;
    foreach (fr[j]) put_byte(fr[j]);
    put_byte(f[7:0]);
    put_byte(f[15:8]);
  endtask

  task automatic expect_good();
    ev_q.push_back(EV_GOOD);
    foreach (fr[j]) exp_q.push_back({j == 0, j == fr.size() - 1, fr[j]});
  endtask

  task automatic send_octet(input logic [7:0] v);
    @(negedge clk);
    oct_valid = 1'b1; oct_data = v;
    @(negedge clk);
    oct_valid = 1'b0;
    repeat (GAP) @(negedge clk);
  endtask

  task automatic flush(input bit pad);
    while (bq.size() > 0) begin
      logic [7:0] v;
      v = mode_56k ? 8'h80 : 8'h00;
      for (int i = 0; i < (mode_56k ? 7 : 8); i++)
        v[i] = (bq.size() > 0) ? bq.pop_front() : pad;
      send_octet(v);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid) begin
        if (exp_q.size() == 0) check(1'b0, "R11 unexpected byte", {out_sof, out_eof, out_data}, 0);
        else begin
          logic [9:0] e;
          e = exp_q.pop_front();
          check({out_sof, out_eof, out_data} == e, "R5 R6 delivered byte", {out_sof, out_eof, out_data}, e);
        end
      end
      if ({evt_good, evt_fcs_err, evt_align_err, evt_oversize, evt_abort} != 5'b0) begin
        logic [4:0] ev;
        ev = {evt_good, evt_fcs_err, evt_align_err, evt_oversize, evt_abort};
        if (ev_q.size() == 0) check(1'b0, "R11 unexpected event", ev, 0);
        else begin
          logic [4:0] e;
          e = ev_q.pop_front();
          check(ev == e, "R2 R6 R8 R9 R10 event", ev, e);
        end
      end
    end
  end

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R11 watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!out_valid, "R1 out_valid in reset", out_valid, 0);
    check({evt_good, evt_fcs_err, evt_align_err, evt_oversize, evt_abort} == 5'b0,
          "R1 events in reset", {evt_good, evt_fcs_err, evt_align_err, evt_oversize, evt_abort}, 0);
    check({cnt_good, cnt_fcs_err, cnt_drop} == '0, "R1 counters in reset",
          {cnt_good, cnt_fcs_err, cnt_drop}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R4 R5 R6: 64k frame whose bytes force zero insertion
    fr = '{8'h7E, 8'hFF, 8'h3F, 8'h01, 8'hF8};
    put_flag(); put_frame(1'b0); put_flag(); expect_good();
    put_ones(8); flush(1'b1);

    // R7: two frames sharing one flag
    fr = '{8'h11, 8'h22, 8'h33};
    put_flag(); put_frame(1'b0); expect_good();
    fr = '{8'hA5, 8'h5A, 8'hC3, 8'h3C};
    put_flag(); put_frame(1'b0); put_flag(); expect_good();
    put_ones(8); flush(1'b1);

    // R6: corrupted check bytes
    fr = '{8'h10, 8'h20, 8'h30};
    put_flag(); put_frame(1'b1); put_flag(); ev_q.push_back(EV_FCS);
    put_ones(8); flush(1'b1);

    // R6: two-byte frame with a valid check is still rejected
    fr = '{};
    put_flag(); put_frame(1'b0); put_flag(); ev_q.push_back(EV_FCS);
    put_ones(8); flush(1'b1);

    // R8: twelve data bits then a flag
    put_flag();
    for (int i = 0; i < 12; i++) bq.push_back(i[0]);
    put_flag(); ev_q.push_back(EV_ALIGN);
    put_ones(8); flush(1'b1);

    // R9: exactly MAX_LEN bytes is accepted
    fr = '{};
    for (int i = 0; i < MAX_LEN - 2; i++) fr.push_back(8'(i * 37 + 5));
    put_flag(); put_frame(1'b0); put_flag(); expect_good();
    put_ones(8); flush(1'b1);

    // R9: one byte more is dropped
    fr = '{};
    for (int i = 0; i < MAX_LEN - 1; i++) fr.push_back(8'(i * 19 + 2));
    put_flag(); put_frame(1'b0); put_flag(); ev_q.push_back(EV_OVER);
    put_ones(8); flush(1'b1);

    // R2: run of ones inside a frame
    put_flag(); put_byte(8'h12); put_byte(8'h34); put_ones(8);
    ev_q.push_back(EV_ABORT);
    flush(1'b1);

    // R3: 56k mode, bit 7 driven high and ignored
    mode_56k = 1'b1;
    fr = '{8'hC0, 8'hFF, 8'h01, 8'h7E};
    put_flag(); put_frame(1'b0); put_flag(); expect_good();
    put_ones(8); flush(1'b1);

    // R10: 56k all-ones octet inside a frame
    put_flag(); put_byte(8'h55); put_byte(8'hAA); flush(1'b0);
    ev_q.push_back(EV_ABORT);
    send_octet(8'h7F);

    // R10: 64k all-ones octet inside a frame
    mode_56k = 1'b0;
    put_flag(); put_byte(8'h0F); flush(1'b0);
    ev_q.push_back(EV_ABORT);
    send_octet(8'hFF);

    repeat (3 * GAP) @(negedge clk);
    check(exp_q.size() == 0, "R6 bytes left undelivered", exp_q.size(), 0);
    check(ev_q.size() == 0, "R11 events left unseen", ev_q.size(), 0);
    check(cnt_good == '1, "R12 good counter saturates", cnt_good, 3);
    check(cnt_fcs_err == CNT_W'(2), "R12 check-error counter", cnt_fcs_err, 2);
    check(cnt_drop == '1, "R12 drop counter saturates", cnt_drop, 3);
    finish_run();
  end
endmodule